// File: doc/BRIEF.md
# DMA Two-Port Address Load Unit

This block keeps the address state of a two-port DMA transfer engine. Each port owns a programmable starting-address register and a working address counter. The CPU writes the starting addresses one byte at a time. A configuration write picks which port acts as source and sets each port's stepping mode and the auto-restart option. Command strobes copy starting addresses into counters, arm the transfer and mark the end of a block.

A LOAD command moves the starting address only into the counter of the port that is currently the source. The destination counter is left alone. To get a fixed destination address, software first makes that port the source, issues LOAD, and then swaps the direction before loading the real source. With auto-restart on, an end-of-block pulse reloads both counters at once from their starting registers, so new addresses take effect without a LOAD. FORCE READY starts transfers only if a LOAD has happened since the last starting-address write. Otherwise it raises an ordering-error flag.

The transfer datapath reads `src_addr` and `dst_addr`. It pulses `xfer_step` once per transfer, and each counter then moves according to its own mode.

Top module: `dma_addr_load_unit`

## Requirements
- R1: After reset, both starting registers and both counters are zero, Port A is the source, both modes are 00 (decrement), auto-restart is off, and `xfer_run` and `order_err` are 0.
- R2: A `reg_wr` writes `wr_data` into byte `byte_sel` (0 = low, 1 = high) of the starting register of port `reg_port` (0 = A, 1 = B). It does not change either counter.
- R3: `cmd_load` copies the source port's starting register into that port's counter on the next edge. The destination port's counter is not loaded.
- R4: `cfg_wr` latches `cfg_a_src`, where 1 makes Port A the source and 0 makes Port B the source. `src_addr` and `dst_addr` are driven combinationally from the counters of the ports in those roles.
- R5: On `xfer_step`, each counter moves by its own 2-bit mode: 00 gives minus one, 01 gives plus one, 1x holds the value. Counters wrap modulo 2^16.
- R6: LOAD arms the unit and any starting-address write disarms it. LOAD wins when both happen in the same cycle. `cmd_force_ready` while armed sets `xfer_run`. While not armed, it sets `order_err` and leaves `xfer_run` unchanged. LOAD clears `order_err`.
- R7: `eob` with auto-restart on reloads both counters from their current starting registers in the same edge and keeps `xfer_run`. Without auto-restart, `eob` clears `xfer_run` and leaves the counters alone.
- R8: In a single cycle, restart reload has priority over LOAD, and LOAD has priority over a step. A starting-address write in the same cycle as a load or reload takes effect only afterwards.
- R9: To set up a fixed destination, load that port while it is temporarily the source, then swap the direction and load the true source. Both counters then hold their intended addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Starting-address byte write strobe |
| reg_port | input | 1 | Port addressed by the write (0 = A, 1 = B) |
| byte_sel | input | 1 | Byte lane of the write (0 = low) |
| wr_data | input | 8 | Byte written |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_a_src | input | 1 | 1: Port A is source, 0: Port B is source |
| cfg_mode_a | input | 2 | Port A step mode |
| cfg_mode_b | input | 2 | Port B step mode |
| cfg_restart | input | 1 | Auto-restart enable |
| cmd_load | input | 1 | LOAD command strobe |
| cmd_force_ready | input | 1 | FORCE READY command strobe |
| eob | input | 1 | End-of-block pulse |
| xfer_step | input | 1 | One transfer completed |
| src_addr | output | 16 | Source-role counter |
| dst_addr | output | 16 | Destination-role counter |
| xfer_run | output | 1 | Transfers enabled by a valid FORCE READY |
| order_err | output | 1 | FORCE READY arrived without a LOAD |

## Verification
The assertions check several things on every cycle. A lone register write leaves both outputs unchanged, and a LOAD lands the source starting value while leaving the destination untouched. A restart lands both starting values. A FORCE READY that is not armed raises the error flag, and `xfer_run` only rises after an armed FORCE READY. Some behaviours can only be shown by the bench's scenarios: the per-mode stepping and wrap-around, the role swap on a direction change, the full fixed-destination setup sequence, and the same-cycle priority between restart, LOAD, step and register write. The bench compares these against its behavioural model on every clock.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;
  localparam int NPORTS = 2;
  localparam int PORT_A = 0;
  localparam int PORT_B = 1;

  localparam logic [1:0] MODE_DEC = 2'b00;
  localparam logic [1:0] MODE_INC = 2'b01;
  localparam logic [1:0] MODE_FIX = 2'b10;

  function automatic logic mode_is_fixed(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/dma_start_reg.sv
module dma_start_reg #(
  parameter int AW = 16,
  localparam int NB = AW / 8,
  localparam int BSW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [BSW-1:0] byte_sel,
  input  logic [7:0]     wr_data,
  output logic [AW-1:0]  start
);
  logic [AW-1:0] start_q;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)
        start_q[b*8 +: 8] <= '0;
      else if (wr_en && (byte_sel == BSW'(b)))
        start_q[b*8 +: 8] <= wr_data;
    end
  end

  assign start = start_q;
endmodule

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr
  import dma_addr_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload,
  input  logic          load,
  input  logic          step,
  input  logic [1:0]    mode,
  input  logic [AW-1:0] start,
  output logic [AW-1:0] cnt
);
  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a,
                                              input logic [1:0] m);
    if (mode_is_fixed(m)) return a;
    else if (m == MODE_INC) return a + AW'(1);
    else return a - AW'(1);
  endfunction

  logic [AW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (reload) cnt_q <= start;
    else if (load)   cnt_q <= start;
    else if (step)   cnt_q <= next_addr(cnt_q, mode);
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/dma_load_seq.sv
module dma_load_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_load,
  input  logic cmd_force_ready,
  input  logic addr_wr,
  input  logic eob,
  input  logic restart_en,
  output logic armed,
  output logic run,
  output logic order_err
);
  logic armed_q, run_q, err_q;
  logic force_ok, force_bad;

  assign force_ok  = cmd_force_ready && armed_q;
  assign force_bad = cmd_force_ready && !armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      run_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (cmd_load)     armed_q <= 1'b1;
      else if (addr_wr) armed_q <= 1'b0;

      if (cmd_load)       err_q <= 1'b0;
      else if (force_bad) err_q <= 1'b1;

      if (force_ok)                 run_q <= 1'b1;
      else if (eob && !restart_en)  run_q <= 1'b0;
    end
  end

  assign armed     = armed_q;
  assign run       = run_q;
  assign order_err = err_q;
endmodule

// File: rtl/dma_addr_load_unit.sv
module dma_addr_load_unit
  import dma_addr_pkg::*;
#(
  parameter int AW = 16,
  localparam int NB = AW / 8,
  localparam int BSW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic           reg_port,
  input  logic [BSW-1:0] byte_sel,
  input  logic [7:0]     wr_data,
  input  logic           cfg_wr,
  input  logic           cfg_a_src,
  input  logic [1:0]     cfg_mode_a,
  input  logic [1:0]     cfg_mode_b,
  input  logic           cfg_restart,
  input  logic           cmd_load,
  input  logic           cmd_force_ready,
  input  logic           eob,
  input  logic           xfer_step,
  output logic [AW-1:0]  src_addr,
  output logic [AW-1:0]  dst_addr,
  output logic           xfer_run,
  output logic           order_err
);
  logic       a_is_src;
  logic [1:0] mode_q [NPORTS];
  logic       restart_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_is_src   <= 1'b1;
      mode_q[0]  <= MODE_DEC;
      mode_q[1]  <= MODE_DEC;
      restart_en <= 1'b0;
    end else if (cfg_wr) begin
      a_is_src   <= cfg_a_src;
      mode_q[0]  <= cfg_mode_a;
      mode_q[1]  <= cfg_mode_b;
      restart_en <= cfg_restart;
    end
  end

  // named internal events
  logic          restart_fire;
  logic          armed;
  logic [AW-1:0] start_v [NPORTS];
  logic [AW-1:0] ctr_v   [NPORTS];
  logic [AW-1:0] start_a, start_b;
  logic [NPORTS-1:0] load_hit;

  assign restart_fire = eob && restart_en;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic is_src;
    assign is_src      = (p == PORT_A) ? a_is_src : !a_is_src;
    assign load_hit[p] = cmd_load && is_src;

    dma_start_reg #(.AW(AW)) u_start (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr && (reg_port == 1'(p))),
      .byte_sel (byte_sel),
      .wr_data  (wr_data),
      .start    (start_v[p])
    );

    dma_addr_ctr #(.AW(AW)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .reload (restart_fire),
      .load   (load_hit[p]),
      .step   (xfer_step),
      .mode   (mode_q[p]),
      .start  (start_v[p]),
      .cnt    (ctr_v[p])
    );
  end

  assign start_a = start_v[PORT_A];
  assign start_b = start_v[PORT_B];

  dma_load_seq u_seq (
    .clk             (clk),
    .rst_n           (rst_n),
    .cmd_load        (cmd_load),
    .cmd_force_ready (cmd_force_ready),
    .addr_wr         (reg_wr),
    .eob             (eob),
    .restart_en      (restart_en),
    .armed           (armed),
    .run             (xfer_run),
    .order_err       (order_err)
  );

  assign src_addr = a_is_src ? ctr_v[PORT_A] : ctr_v[PORT_B];
  assign dst_addr = a_is_src ? ctr_v[PORT_B] : ctr_v[PORT_A];
endmodule

// File: rtl/dma_addr_load_chk.sv
module dma_addr_load_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          cfg_wr,
  input logic          cmd_load,
  input logic          cmd_force_ready,
  input logic          eob,
  input logic          xfer_step,
  input logic [AW-1:0] src_addr,
  input logic [AW-1:0] dst_addr,
  input logic          xfer_run,
  input logic          order_err,
  input logic          a_is_src,
  input logic          armed,
  input logic          restart_fire,
  input logic [AW-1:0] start_a,
  input logic [AW-1:0] start_b
);
  logic [AW-1:0] src_start, dst_start;
  assign src_start = a_is_src ? start_a : start_b;
  assign dst_start = a_is_src ? start_b : start_a;

  AST_WRITE_KEEPS_CTR: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && !cmd_load && !xfer_step && !eob && !cfg_wr
    |=> $stable(src_addr) && $stable(dst_addr)); // R2

  AST_LOAD_HITS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_load && !restart_fire && !cfg_wr
    |=> src_addr == $past(src_start)); // R3

  AST_LOAD_SKIPS_DST: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_load && !restart_fire && !cfg_wr && !xfer_step
    |=> $stable(dst_addr)); // R3

  AST_RESTART_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    restart_fire && !cfg_wr
    |=> src_addr == $past(src_start) && dst_addr == $past(dst_start)); // R7

  AST_FORCE_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_force_ready && !armed && !cmd_load && !eob
    |=> order_err && xfer_run == $past(xfer_run)); // R6

  AST_RUN_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_run) |-> $past(cmd_force_ready && armed)); // R6
endmodule

bind dma_addr_load_unit dma_addr_load_chk #(.AW(AW)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .reg_wr          (reg_wr),
  .cfg_wr          (cfg_wr),
  .cmd_load        (cmd_load),
  .cmd_force_ready (cmd_force_ready),
  .eob             (eob),
  .xfer_step       (xfer_step),
  .src_addr        (src_addr),
  .dst_addr        (dst_addr),
  .xfer_run        (xfer_run),
  .order_err       (order_err),
  .a_is_src        (a_is_src),
  .armed           (armed),
  .restart_fire    (restart_fire),
  .start_a         (start_a),
  .start_b         (start_b)
);

// File: tb/dma_addr_load_unit_tb.sv
module dma_addr_load_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 0, reg_port = 0, byte_sel = 0;
  logic [7:0] wr_data = 0;
  logic cfg_wr = 0, cfg_a_src = 0, cfg_restart = 0;
  logic [1:0] cfg_mode_a = 0, cfg_mode_b = 0;
  logic cmd_load = 0, cmd_force_ready = 0, eob = 0, xfer_step = 0;
  logic [15:0] src_addr, dst_addr;
  logic xfer_run, order_err;

  int total = 0, bad = 0;
  string phase = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_addr_load_unit u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_port(reg_port),
    .byte_sel(byte_sel), .wr_data(wr_data), .cfg_wr(cfg_wr),
    .cfg_a_src(cfg_a_src), .cfg_mode_a(cfg_mode_a), .cfg_mode_b(cfg_mode_b),
    .cfg_restart(cfg_restart), .cmd_load(cmd_load),
    .cmd_force_ready(cmd_force_ready), .eob(eob), .xfer_step(xfer_step),
    .src_addr(src_addr), .dst_addr(dst_addr), .xfer_run(xfer_run),
    .order_err(order_err)
  );

  // behavioural reference model
  int m_start[2], m_cnt[2], m_mode[2];
  int m_asrc, m_rs, m_armed, m_run, m_err;

  function automatic int stepped(int v, int md);
    if (md >= 2) return v;
    if (md == 1) return (v + 1) % 65536;
    return (v + 65535) % 65536;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_start = '{0, 0}; m_cnt = '{0, 0}; m_mode = '{0, 0};
      m_asrc = 1; m_rs = 0; m_armed = 0; m_run = 0; m_err = 0;
    end else begin
      int srcp, nxt[2];
      srcp = m_asrc ? 0 : 1;
      for (int p = 0; p < 2; p++) begin
        if (eob && m_rs)            nxt[p] = m_start[p];
        else if (cmd_load && p == srcp) nxt[p] = m_start[p];
        else if (xfer_step)         nxt[p] = stepped(m_cnt[p], m_mode[p]);
        else                        nxt[p] = m_cnt[p];
      end
      if (cmd_force_ready && m_armed) m_run = 1;
      else if (eob && !m_rs)          m_run = 0;
      if (cmd_load) m_err = 0;
      else if (cmd_force_ready && !m_armed) m_err = 1;
      if (cmd_load) m_armed = 1;
      else if (reg_wr) m_armed = 0;
      m_cnt = nxt;
      if (reg_wr) begin
        if (byte_sel) m_start[reg_port] = (m_start[reg_port] % 256) + int'(wr_data) * 256;
        else          m_start[reg_port] = (m_start[reg_port] / 256) * 256 + int'(wr_data);
      end
      if (cfg_wr) begin
        m_asrc = cfg_a_src; m_mode[0] = cfg_mode_a; m_mode[1] = cfg_mode_b;
        m_rs = cfg_restart;
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(phase, "model src", int'(src_addr), m_asrc ? m_cnt[0] : m_cnt[1]);
      chk(phase, "model dst", int'(dst_addr), m_asrc ? m_cnt[1] : m_cnt[0]);
      chk(phase, "model run", int'(xfer_run), m_run);
      chk(phase, "model err", int'(order_err), m_err);
    end
  end

  task automatic tick();
    @(posedge clk); #2;
    reg_wr = 0; cfg_wr = 0; cmd_load = 0; cmd_force_ready = 0; eob = 0; xfer_step = 0;
  endtask

  task automatic wr_start(logic p, logic [15:0] v);
    reg_wr = 1; reg_port = p; byte_sel = 0; wr_data = v[7:0]; tick();
    reg_wr = 1; reg_port = p; byte_sel = 1; wr_data = v[15:8]; tick();
  endtask

  task automatic cfg(logic asrc, logic [1:0] ma, logic [1:0] mb, logic rs);
    cfg_wr = 1; cfg_a_src = asrc; cfg_mode_a = ma; cfg_mode_b = mb; cfg_restart = rs;
    tick();
  endtask

  task automatic load();  cmd_load = 1; tick(); endtask
  task automatic step();  xfer_step = 1; tick(); endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    tick();
    phase = "R1";
    chk("R1", "reset src", src_addr, 0); chk("R1", "reset dst", dst_addr, 0);
    chk("R1", "reset run", xfer_run, 0); chk("R1", "reset err", order_err, 0);

    phase = "R2";
    wr_start(0, 16'h1234);
    chk("R2", "write leaves ctr", src_addr, 0);

    phase = "R3";
    load();
    chk("R3", "load src", src_addr, 16'h1234); chk("R3", "load dst", dst_addr, 0);
    wr_start(1, 16'hBEEF); load();
    chk("R3", "dst not loaded", dst_addr, 0); chk("R3", "src kept", src_addr, 16'h1234);

    phase = "R5";
    cfg(1, 2'b01, 2'b10, 0);
    repeat (3) step();
    chk("R5", "inc mode", src_addr, 16'h1237); chk("R5", "fixed mode", dst_addr, 0);
    cfg(1, 2'b00, 2'b11, 0); step();
    chk("R5", "dec mode", src_addr, 16'h1236);
    wr_start(0, 16'h0000); load(); step();
    chk("R5", "dec wrap", src_addr, 16'hFFFF);

    phase = "R4";
    cfg(0, 2'b00, 2'b10, 0);
    chk("R4", "B as src", src_addr, 0); chk("R4", "A as dst", dst_addr, 16'hFFFF);

    phase = "R9";
    wr_start(1, 16'h8000); load();
    wr_start(0, 16'h0100); cfg(1, 2'b01, 2'b10, 0); load();
    chk("R9", "true src", src_addr, 16'h0100); chk("R9", "fixed dst", dst_addr, 16'h8000);
    step(); step();
    chk("R9", "src stepped", src_addr, 16'h0102); chk("R9", "dst held", dst_addr, 16'h8000);

    phase = "R6";
    cmd_force_ready = 1; tick();
    chk("R6", "armed run", xfer_run, 1); chk("R6", "armed err", order_err, 0);
    wr_start(0, 16'h0300);
    cmd_force_ready = 1; tick();
    chk("R6", "unarmed err", order_err, 1); chk("R6", "run kept", xfer_run, 1);
    load();
    chk("R6", "load clears err", order_err, 0); chk("R6", "reloaded", src_addr, 16'h0300);

    phase = "R7";
    cfg(1, 2'b01, 2'b10, 1);
    wr_start(0, 16'h2000); wr_start(1, 16'h9000); step();
    chk("R7", "pre eob", src_addr, 16'h0301);
    eob = 1; tick();
    chk("R7", "restart src", src_addr, 16'h2000); chk("R7", "restart dst", dst_addr, 16'h9000);
    chk("R7", "restart keeps run", xfer_run, 1);
    cfg(1, 2'b01, 2'b10, 0); step();
    eob = 1; tick();
    chk("R7", "eob stops run", xfer_run, 0); chk("R7", "eob no reload", src_addr, 16'h2001);

    phase = "R8";
    cmd_load = 1; xfer_step = 1; tick();
    chk("R8", "load over step", src_addr, 16'h2000);
    reg_wr = 1; reg_port = 0; byte_sel = 0; wr_data = 8'h55; cmd_load = 1; tick();
    chk("R8", "old start on load", src_addr, 16'h2000);
    load();
    chk("R8", "new start later", src_addr, 16'h2055);
    cfg(1, 2'b01, 2'b01, 1);
    eob = 1; cmd_load = 1; xfer_step = 1; tick();
    chk("R8", "restart over all", dst_addr, 16'h9000);

    phase = "R8";
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(0, 9);
      reg_wr = (r == 0); reg_port = 1'($urandom); byte_sel = 1'($urandom);
      wr_data = 8'($urandom);
      cfg_wr = (r == 1); cfg_a_src = 1'($urandom); cfg_mode_a = 2'($urandom);
      cfg_mode_b = 2'($urandom); cfg_restart = 1'($urandom);
      cmd_load = (r == 2) || ($urandom_range(0, 15) == 0);
      cmd_force_ready = (r == 3);
      eob = (r == 4);
      xfer_step = ($urandom_range(0, 2) != 0);
      tick();
    end

    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule